// File: doc/BRIEF.md
# Eight-input programmable interrupt controller

The block collects eight interrupt request lines. Each request can be masked, it is ranked at a fixed priority, and the processor is signalled through a single interrupt output. When the processor returns an acknowledge strobe, the block marks the winning request as in service and presents an 8-bit vector on its vector output. That vector is a programmed base plus the request index.

Software sets the block up through a two-address register port. A configuration word written to the even address starts a short programming sequence on the odd address. That sequence delivers a vector base, then an optional cascade word (stored nowhere), then an optional mode word. Once the sequence is over, the odd address holds the mask register. The even address then accepts end-of-interrupt commands and a command that chooses whether even-address reads return the pending register or the in-service register.

Request lines are either edge triggered or level triggered, as chosen by the configuration word. The mode word can enable automatic end-of-interrupt. In that mode the in-service register is left untouched by an acknowledge.

Top module: `intr_ctrl8`

## Requirements
- R1: An even-address write with data bit 4 set is a configuration word. It clears the mask, pending and in-service registers, latches data bits 3, 1 and 0, and makes the next odd-address write the vector-base word.
- R2: The vector-base word keeps data bits 7:3 as the vector base. Bits 2:0 are dropped.
- R3: After the vector-base word, one cascade word is consumed only if configuration bit 1 was 0. After that, one mode word is consumed only if configuration bit 0 was 1. None of these words changes the mask register.
- R4: Outside the programming sequence, an odd-address write loads the mask register, and an odd-address read returns it. A mask bit of 1 disables its request.
- R5: An even-address write with bits 4 and 3 both 0 ends an interrupt. If bits 7:5 are 011, it clears the in-service bit selected by bits 2:0. Otherwise it clears the lowest-numbered set in-service bit.
- R6: An even-address write with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects what even-address reads return: the in-service register if bit 0 = 1, the pending register if bit 0 = 0.
- R7: Request 0 has the highest priority and request 7 the lowest. A request is granted only if it is pending, unmasked, and neither it nor any lower-numbered request is in service.
- R8: `int_out` is 1 exactly when some request could be granted.
- R9: An acknowledge with a granted request sets that request's in-service bit. The same clock edge loads `vec_out` with the base shifted left by 3, plus the request index.
- R10: In edge mode (configuration bit 3 = 0), a pending bit is set by a 0-to-1 transition of its input. An acknowledge clears it even while the input is still high.
- R11: In level mode (configuration bit 3 = 1), each pending bit follows its input one clock later. The pending bit therefore stays set across an acknowledge while the input remains high.
- R12: If mode-word bit 1 is 1, automatic end-of-interrupt is enabled. An acknowledge then still delivers the vector but leaves the in-service register unchanged.
- R13: Reset gives a mask of 0xFF, a vector base of 0x08 (base field 00001), the in-service register as the read selection, edge mode, and empty pending and in-service registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address: 0 = command, 1 = data/mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq_in | input | 8 | Request inputs, bit 0 highest priority |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge strobe, one clock wide |
| vec_out | output | 8 | Vector captured on acknowledge |

## Verification
The bench builds the block with its fixed width of eight requests. At that width every request pattern is within reach of a sweep. The sweep raises all 255 non-empty patterns and drains each one by acknowledge and end-of-interrupt, so the full priority order and the vector arithmetic are compared at every step. Separate sweeps cover all four skip combinations of the programming sequence and all eight mask boundaries. Directed passes cover nesting against the priority block, both end-of-interrupt forms, level-mode retention and automatic end-of-interrupt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REQ_N = 8;
  localparam int IDX_W = $clog2(REQ_N);
  localparam int DW    = 8;
  localparam int BASE_W = DW - IDX_W;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_t;

  localparam int B_CFG  = 4;
  localparam int B_SEL  = 3;
  localparam int B_LVL  = 3;
  localparam int B_NOCS = 1;
  localparam int B_MODE = 0;
  localparam int B_AEOI = 1;
  localparam logic [2:0] EOI_SPEC_CODE = 3'b011;
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      mask_o,
  output logic [BASE_W-1:0] base_o,
  output logic              level_o,
  output logic              auto_eoi_o,
  output logic              rd_isr_o,
  output logic              init_o,
  output logic              eoi_o,
  output logic              eoi_spec_o,
  output logic [IDX_W-1:0]  eoi_idx_o
);
  seq_t              seq_q, seq_d;
  logic [W-1:0]      mask_q, mask_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              lvl_q, lvl_d;
  logic              nocs_q, nocs_d;
  logic              mreq_q, mreq_d;
  logic              aeoi_q, aeoi_d;
  logic              rsel_q, rsel_d;
  logic              cfg_w, eoi_w, sel_w, odd_w;
  logic              mask_en, base_en, mode_en, rsel_en;

  always_comb begin
    cfg_w = wr_en && !addr && wdata[B_CFG];
    eoi_w = wr_en && !addr && !wdata[B_CFG] && !wdata[B_SEL];
    sel_w = wr_en && !addr && !wdata[B_CFG] && wdata[B_SEL] && wdata[1];
    odd_w = wr_en && addr;
    mask_en = cfg_w || (odd_w && seq_q == SEQ_RUN);
    base_en = odd_w && seq_q == SEQ_BASE;
    mode_en = odd_w && seq_q == SEQ_MODE;
    rsel_en = sel_w;
  end

  always_comb begin
    seq_d  = seq_q;
    mask_d = mask_q;
    base_d = base_q;
    lvl_d  = lvl_q;
    nocs_d = nocs_q;
    mreq_d = mreq_q;
    aeoi_d = aeoi_q;
    rsel_d = rsel_q;
    if (cfg_w) begin
      seq_d  = SEQ_BASE;
      lvl_d  = wdata[B_LVL];
      nocs_d = wdata[B_NOCS];
      mreq_d = wdata[B_MODE];
    end else if (odd_w) begin
      unique case (seq_q)
        SEQ_BASE: begin
          if (!nocs_q)     seq_d = SEQ_CASC;
          else if (mreq_q) seq_d = SEQ_MODE;
          else             seq_d = SEQ_RUN;
        end
        SEQ_CASC: seq_d = mreq_q ? SEQ_MODE : SEQ_RUN;
        SEQ_MODE: seq_d = SEQ_RUN;
        default:  seq_d = SEQ_RUN;
      endcase
    end
    if (mask_en) mask_d = cfg_w ? '0 : wdata;
    if (base_en) base_d = wdata[W-1:IDX_W];
    if (mode_en) aeoi_d = wdata[B_AEOI];
    if (rsel_en) rsel_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SEQ_RUN;
      mask_q <= '1;
      base_q <= BASE_W'(1);
      lvl_q  <= 1'b0;
      nocs_q <= 1'b0;
      mreq_q <= 1'b0;
      aeoi_q <= 1'b0;
      rsel_q <= 1'b1;
    end else begin
      seq_q  <= seq_d;
      mask_q <= mask_d;
      base_q <= base_d;
      lvl_q  <= lvl_d;
      nocs_q <= nocs_d;
      mreq_q <= mreq_d;
      aeoi_q <= aeoi_d;
      rsel_q <= rsel_d;
    end
  end

  assign mask_o     = mask_q;
  assign base_o     = base_q;
  assign level_o    = lvl_q;
  assign auto_eoi_o = aeoi_q;
  assign rd_isr_o   = rsel_q;
  assign init_o     = cfg_w;
  assign eoi_o      = eoi_w;
  assign eoi_spec_o = (wdata[7:5] == EOI_SPEC_CODE);
  assign eoi_idx_o  = wdata[IDX_W-1:0];

  AST_CFG_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_w |=> (mask_q == '0)); // R1
  AST_SEQ_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_w && seq_q != SEQ_RUN) |=> $stable(mask_q)); // R3
  AST_RUN_LOADS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_w && seq_q == SEQ_RUN) |=> (mask_q == $past(wdata))); // R4
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend
  import irqc_pkg::*;
#(
  parameter int N = REQ_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         level_i,
  input  logic         init_clr_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] irq_q, pend_q, pend_d, rise;

  always_comb begin
    rise = irq_in & ~irq_q;
    if (init_clr_i)   pend_d = '0;
    else if (level_i) pend_d = irq_in;
    else              pend_d = (pend_q & ~ack_clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && !init_clr_i) |=> ((pend_q & $past(rise)) == $past(rise))); // R10
  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i && !init_clr_i) |=> (pend_q == $past(irq_in))); // R11
  AST_INIT_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr_i |=> (pend_q == '0)); // R1
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter int N = REQ_N,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  isr_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N-1:0] block, elig;
  logic [N:0]   taken;

  assign block[0] = isr_i[0];
  assign taken[0] = 1'b0;

  for (genvar i = 1; i < N; i++) begin : g_block
    assign block[i] = block[i-1] | isr_i[i];
  end

  assign elig = pend_i & ~mask_i & ~block;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant_o[i]  = elig[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | elig[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (grant_o[i]) idx_o = IW'(i);
    end
  end

  assign any_o = taken[N];

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R7
  AST_GRANT_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) |-> (((grant_o | (grant_o - 1'b1)) & isr_i) == '0)); // R7
  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) |-> ((grant_o & pend_i & ~mask_i) == grant_o)); // R8
endmodule

// File: rtl/irqc_isr.sv
module irqc_isr
  import irqc_pkg::*;
#(
  parameter int N = REQ_N,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_i,
  input  logic [N-1:0]  grant_i,
  input  logic          auto_eoi_i,
  input  logic          init_clr_i,
  input  logic          eoi_i,
  input  logic          eoi_spec_i,
  input  logic [IW-1:0] eoi_idx_i,
  output logic [N-1:0]  isr_o
);
  logic [N-1:0] isr_q, isr_d, low, set_v, clr_v;
  logic [N:0]   seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_low
    assign low[i]    = isr_q[i] & ~seen[i];
    assign seen[i+1] = seen[i] | isr_q[i];
  end

  always_comb begin
    set_v = (ack_i && !auto_eoi_i) ? grant_i : '0;
    clr_v = '0;
    if (eoi_i) clr_v = eoi_spec_i ? (N'(1) << eoi_idx_i) : low;
    if (init_clr_i) isr_d = '0;
    else            isr_d = (isr_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assign isr_o = isr_q;

  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && (|grant_i) && !auto_eoi_i && !init_clr_i && !eoi_i)
      |=> ((isr_q & $past(grant_i)) != '0)); // R9
  AST_AUTO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && auto_eoi_i && !init_clr_i && !eoi_i) |=> (isr_q == $past(isr_q))); // R12
  AST_SPEC_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && eoi_spec_i && !ack_i && !init_clr_i) |=> !isr_q[$past(eoi_idx_i)]); // R5
  AST_INIT_CLEARS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr_i |=> (isr_q == '0)); // R1
endmodule

// File: rtl/intr_ctrl8.sv
module intr_ctrl8
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [REQ_N-1:0] irq_in,
  output logic             int_out,
  input  logic             ack,
  output logic [DW-1:0]    vec_out
);
  logic [1:0]        rst_sync;
  logic              rst_s;
  logic [REQ_N-1:0]  mask, pend, isr, grant, ack_clr;
  logic [BASE_W-1:0] base;
  logic [IDX_W-1:0]  gidx, eoi_idx;
  logic              level, auto_eoi, rd_isr, init_w, eoi_w, eoi_spec, any;
  logic [DW-1:0]     vec_q, vec_d;
  logic              vec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  irqc_cfg #(.W(DW)) u_cfg (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mask_o(mask), .base_o(base), .level_o(level), .auto_eoi_o(auto_eoi),
    .rd_isr_o(rd_isr), .init_o(init_w), .eoi_o(eoi_w), .eoi_spec_o(eoi_spec),
    .eoi_idx_o(eoi_idx)
  );

  assign ack_clr = ack ? grant : '0;

  irqc_pend #(.N(REQ_N)) u_pend (
    .clk(clk), .rst_n(rst_s), .irq_in(irq_in), .level_i(level),
    .init_clr_i(init_w), .ack_clr_i(ack_clr), .pend_o(pend)
  );

  irqc_prio #(.N(REQ_N), .IW(IDX_W)) u_prio (
    .clk(clk), .rst_n(rst_s), .pend_i(pend), .mask_i(mask), .isr_i(isr),
    .grant_o(grant), .idx_o(gidx), .any_o(any)
  );

  irqc_isr #(.N(REQ_N), .IW(IDX_W)) u_isr (
    .clk(clk), .rst_n(rst_s), .ack_i(ack), .grant_i(grant),
    .auto_eoi_i(auto_eoi), .init_clr_i(init_w), .eoi_i(eoi_w),
    .eoi_spec_i(eoi_spec), .eoi_idx_i(eoi_idx), .isr_o(isr)
  );

  always_comb begin
    vec_en = ack && any;
    vec_d  = {base, {IDX_W{1'b0}}} + {{BASE_W{1'b0}}, gidx};
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign vec_out = vec_q;
  assign int_out = any;

  always_comb begin
    if (addr)        rdata = mask;
    else if (rd_isr) rdata = isr;
    else             rdata = pend;
  end

  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_s)
    (ack && any) |=> (vec_out[DW-1:IDX_W] == $past(base))); // R9
  AST_VEC_INDEX: assert property (@(posedge clk) disable iff (!rst_s)
    (ack && any) |=> ($past(grant) == (REQ_N'(1) << vec_out[IDX_W-1:0]))); // R7
endmodule

// File: tb/intr_ctrl8_test.sv
module intr_ctrl8_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic       int_out;
  logic       ack = 1'b0;
  logic [7:0] vec_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  intr_ctrl8 uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .ack(ack),
    .vec_out(vec_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %02h expected %02h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic init_seq(input logic [7:0] cw, input logic [7:0] vw, input logic [7:0] mw);
    wr(1'b0, cw);
    wr(1'b1, vw);
    if (!cw[1]) wr(1'b1, 8'h00);
    if (cw[0])  wr(1'b1, mw);
  endtask

  function automatic int lowest(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] rem;
    int idx;
    int nw;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset values
    rd(1'b1, r); chk("R13 mask", r, 8'hFF);
    rd(1'b0, r); chk("R13 isr", r, 8'h00);
    chk("R13 int_out", {7'b0, int_out}, 8'h00);
    // R6 select pending, then back
    wr(1'b0, 8'h0A); rd(1'b0, r); chk("R6 pending empty", r, 8'h00);
    wr(1'b0, 8'h0B);

    // R3 sequence skipping, all four combinations
    for (int k = 0; k < 4; k++) begin
      nw = 1 + ((k & 2) ? 0 : 1) + ((k & 1) ? 1 : 0);
      wr(1'b0, 8'h10 | 8'(k));
      rd(1'b1, r); chk("R1 mask cleared", r, 8'h00);
      for (int j = 0; j < nw; j++) begin
        wr(1'b1, 8'hA0 + 8'(j));
        rd(1'b1, r); chk("R3 word consumed", r, 8'h00);
      end
      wr(1'b1, 8'h5A);
      rd(1'b1, r); chk("R4 mask load", r, 8'h5A);
    end

    // R2 vector base drops low bits
    init_seq(8'h13, 8'h27, 8'h01);
    set_irq(8'h01);
    do_ack();
    chk("R2 vector base", vec_out, 8'h20);
    wr(1'b0, 8'h20);
    set_irq(8'h00);

    // R7 R8 R9 R10 exhaustive pattern sweep
    init_seq(8'h13, 8'h20, 8'h01);
    for (int p = 1; p < 256; p++) begin
      set_irq(8'(p));
      wr(1'b0, 8'h0A);
      rd(1'b0, r); chk("R10 pending on rise", r, 8'(p));
      wr(1'b0, 8'h0B);
      rem = 8'(p);
      while (rem != 8'h00) begin
        idx = lowest(rem);
        chk("R8 int_out", {7'b0, int_out}, 8'h01);
        do_ack();
        chk("R7 priority vector", vec_out, 8'h20 + 8'(idx));
        rd(1'b0, r); chk("R9 in-service set", r, 8'h01 << idx);
        rem[idx] = 1'b0;
        wr(1'b0, 8'h20);
        rd(1'b0, r); chk("R5 non-specific clear", r, 8'h00);
      end
      chk("R10 acked edge stays clear", {7'b0, int_out}, 8'h00);
      set_irq(8'h00);
    end

    // R4 mask boundaries
    for (int i = 0; i < 8; i++) begin
      init_seq(8'h13, 8'h40, 8'h01);
      wr(1'b1, (8'h01 << i) - 8'h01);
      set_irq(8'hFF);
      chk("R4 int with mask", {7'b0, int_out}, 8'h01);
      do_ack();
      chk("R4 first unmasked", vec_out, 8'h40 + 8'(i));
      set_irq(8'h00);
    end
    init_seq(8'h13, 8'h40, 8'h01);
    wr(1'b1, 8'hFF);
    set_irq(8'hFF);
    chk("R8 all masked", {7'b0, int_out}, 8'h00);
    set_irq(8'h00);

    // R7 nesting and R5 specific EOI
    init_seq(8'h13, 8'h60, 8'h01);
    set_irq(8'h20); do_ack();
    chk("R9 vector 5", vec_out, 8'h65);
    set_irq(8'hA0);
    chk("R7 lower blocked", {7'b0, int_out}, 8'h00);
    set_irq(8'hA4);
    chk("R7 higher passes", {7'b0, int_out}, 8'h01);
    do_ack();
    chk("R7 nested vector", vec_out, 8'h62);
    rd(1'b0, r); chk("R9 nested isr", r, 8'h24);
    wr(1'b0, 8'h65);
    rd(1'b0, r); chk("R5 specific clear", r, 8'h04);
    chk("R7 still blocked by 2", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h20);
    rd(1'b0, r); chk("R5 non-specific", r, 8'h00);
    chk("R8 pending 7 released", {7'b0, int_out}, 8'h01);
    do_ack();
    chk("R9 vector 7", vec_out, 8'h67);
    wr(1'b0, 8'h67);
    rd(1'b0, r); chk("R5 specific 7", r, 8'h00);
    set_irq(8'h00);

    // R11 level mode
    init_seq(8'h1B, 8'h80, 8'h00);
    set_irq(8'h10);
    chk("R11 level int", {7'b0, int_out}, 8'h01);
    do_ack();
    chk("R11 level vector", vec_out, 8'h84);
    wr(1'b0, 8'h0A);
    rd(1'b0, r); chk("R11 pending held", r, 8'h10);
    wr(1'b0, 8'h20);
    chk("R11 reasserts", {7'b0, int_out}, 8'h01);
    set_irq(8'h00);
    rd(1'b0, r); chk("R11 pending follows low", r, 8'h00);
    chk("R11 int drops", {7'b0, int_out}, 8'h00);

    // R12 automatic end-of-interrupt
    init_seq(8'h13, 8'hC0, 8'h02);
    wr(1'b0, 8'h0B);
    set_irq(8'h40); do_ack();
    chk("R12 vector", vec_out, 8'hC6);
    rd(1'b0, r); chk("R12 isr untouched", r, 8'h00);
    set_irq(8'h48);
    chk("R12 no block", {7'b0, int_out}, 8'h01);
    do_ack();
    chk("R12 next vector", vec_out, 8'hC3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule